// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block keeps a short first-in, first-out store of instruction bytes filled ahead of an execution unit. It owns a sequential code pointer and, whenever the store has room for a whole bus word, starts a code fetch on a single request/acknowledge memory port (20-bit byte address, 16-bit data). The execution unit pulls one byte per clock from the head of the store through a pop port that carries a valid flag.

The same memory port also carries the execution unit's operand reads and writes. These always win arbitration against prefetching, so prefetching is suspended while an operand access is pending and resumes once it has finished. When the execution unit takes a jump it drives a redirect with the target address. The block then discards every queued byte and restarts fetching at the target. A code fetch that is already on the bus at that moment runs to completion, and its returned word is thrown away.

Each bus cycle lasts at least four clocks. The acknowledge is looked at only from the fourth clock of a cycle on, so a slower memory adds wait states by keeping it low. One idle clock separates successive bus cycles.

Top module: `prefetch_queue_ctrl`

## Requirements
- R1: The store holds at most six bytes. Bytes leave through the pop port in the order they were fetched, and the head byte is offered whenever `eu_byte_valid` is high.
- R2: A code fetch begins only when at least two byte slots are free, that is, when the store holds four bytes or fewer at the start of the bus cycle. A store holding five or six bytes starts no code fetch.
- R3: Code fetches present an even (word-aligned) address with `mem_we` low. Address, write enable and write data stay unchanged while `mem_req` is high until the cycle is accepted. A write presents the operand's address and data unchanged.
- R4: A bus cycle keeps `mem_req` high for at least four clocks. The acknowledge is accepted on the fourth clock or on the first later clock where it is high, so a memory that delays its acknowledge lengthens the cycle.
- R5: A pending operand request wins over a pending prefetch at the start of every bus cycle. `eu_data_done` is high for exactly the accepting clock, with the read word on `eu_data_rdata`, and code prefetching resumes afterwards.
- R6: A redirect empties the store: `eu_byte_valid` is low on the clock after `eu_jmp`. The next code fetch targets the word holding the target address, and a pop in the redirect clock removes nothing.
- R7: A code fetch in flight when a redirect arrives completes on the bus, but its data is not enqueued.
- R8: When the code pointer is odd, only the high byte (bits 15:8) of the returned word is enqueued and the pointer advances by one. When it is even, the low byte (bits 7:0) is enqueued first, then the high byte, and the pointer advances by two.
- R9: A pop while the store is empty is ignored. Nothing is removed, and the first byte to arrive afterwards is still offered.
- R10: After reset the store is empty, the bus is idle, and the first bus cycle is a code fetch at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Bus cycle in progress |
| mem_we | output | 1 | 1 = write cycle |
| mem_addr | output | 20 | Byte address of the cycle |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory ready to complete the cycle |
| eu_pop | input | 1 | Take the head byte |
| eu_byte_valid | output | 1 | Store not empty |
| eu_byte | output | 8 | Head byte |
| eu_jmp | input | 1 | Redirect strobe |
| eu_jmp_addr | input | 20 | Redirect target |
| eu_data_req | input | 1 | Operand access request, held until done |
| eu_data_we | input | 1 | Operand access is a write |
| eu_data_addr | input | 20 | Operand byte address |
| eu_data_wdata | input | 16 | Operand write data |
| eu_data_done | output | 1 | Operand access accepted this clock |
| eu_data_rdata | output | 16 | Operand read word |

## Verification
The hardest situation to reach from the ports is a redirect that lands while a code fetch is still on the bus, because the dropped word must not reach the store. The bench lengthens bus cycles to ten clocks with a slow acknowledge. It first redirects once so that a fresh code fetch starts, then redirects again two clocks into that fetch, and checks that the old cycle is still on the bus while the bytes popped afterwards all come from the new target. Operand priority is reached the same way: an operand request is raised in the middle of a code fetch, and the next cycle to start must be the operand access.

// File: rtl/fq_pkg.sv
// Shared types for the prefetch queue controller.
// Assumes a 16-bit memory data path split into two byte lanes.
package fq_pkg;
    localparam int WORD_W = 16;

    // Kind of bus cycle currently owned by the sequencer
    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_CODE = 2'd1,
        CYC_DATA = 2'd2
    } cyc_e;
endpackage

// File: rtl/fq_bytequeue.sv
// Byte store for prefetched code: circular buffer of DEPTH bytes.
// Accepts zero, one or two bytes per clock and releases at most one.
// A flush empties it in one clock and overrides push and pop.
// Assumes the writer never pushes more than the free space (the
// fetch logic starts a word fetch only with two slots free).
module fq_bytequeue #(
    parameter int DEPTH = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic [1:0]                     push_n,
    input  logic [7:0]                     push_b0,
    input  logic [7:0]                     push_b1,
    input  logic                           pop,
    output logic [7:0]                     head,
    output logic                           valid,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int IW   = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH+1);
    localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

    logic [7:0]    slot [DEPTH];
    logic [IW-1:0] rd_idx;
    logic [IW-1:0] wr_idx;
    logic          take;

    // Modulo-DEPTH index advance (DEPTH need not be a power of two)
    function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] i, input int k);
        int s;
        s = int'(i) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return IW'(s);
    endfunction

    assign take  = pop && valid && !flush;
    assign valid = (count != '0);
    assign head  = slot[rd_idx];

    // Byte storage: write one or two incoming bytes at the tail
    always_ff @(posedge clk) begin
        if (!flush) begin
            if (push_n != 2'd0) slot[wr_idx] <= push_b0;
            if (push_n == 2'd2) slot[wrap_add(wr_idx, 1)] <= push_b1;
        end
    end

    // Read/write indices and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_idx <= '0;
            wr_idx <= '0;
            count  <= '0;
        end else begin
            if (take) rd_idx <= wrap_add(rd_idx, 1);
            wr_idx <= wrap_add(wr_idx, int'(push_n));
            count  <= count + CNTW'(push_n) - CNTW'(take);
        end
    end

    // R1: occupancy never exceeds the store size
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);

    // R9: popping an empty store with nothing arriving leaves it empty
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !valid && push_n == 2'd0 && !flush) |=> (count == '0));
endmodule

// File: rtl/fq_busseq.sv
// Bus cycle sequencer: owns the single memory port.
// From idle it starts one cycle, giving operand accesses priority over
// code fetches, then holds request, address and data steady. It
// accepts the acknowledge from the BUS_CLKS-th clock of the cycle on,
// then returns to idle for one clock.
// Assumes the requester of an operand access drops its request in the
// clock after it sees the access complete.
module fq_busseq import fq_pkg::*; #(
    parameter int ADDR_W   = 20,
    parameter int BUS_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_want,
    input  logic [ADDR_W-1:0] code_addr,
    input  logic              data_want,
    input  logic              data_we,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [WORD_W-1:0] data_wdata,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              done,
    output cyc_e              cur
);
    localparam int CW = (BUS_CLKS > 2) ? $clog2(BUS_CLKS) : 1;
    localparam logic [CW-1:0] LAST    = CW'(BUS_CLKS - 1);
    localparam logic [CW:0]   LEN_MAX = (CW+1)'(BUS_CLKS);

    logic          busy;
    logic [CW-1:0] cnt;

    assign mem_req = busy;
    assign done    = busy && mem_ack && (cnt == LAST);

    // Cycle start, arbitration, clock counting and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cur       <= CYC_NONE;
            cnt       <= '0;
            mem_addr  <= '0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
        end else if (!busy) begin
            cnt <= '0;
            if (data_want) begin
                busy      <= 1'b1;
                cur       <= CYC_DATA;
                mem_addr  <= data_addr;
                mem_we    <= data_we;
                mem_wdata <= data_wdata;
            end else if (code_want) begin
                busy     <= 1'b1;
                cur      <= CYC_CODE;
                mem_addr <= code_addr;
                mem_we   <= 1'b0;
            end else begin
                cur <= CYC_NONE;
            end
        end else if (done) begin
            busy <= 1'b0;
            cur  <= CYC_NONE;
        end else if (cnt != LAST) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Checker state: length of the current request, saturating
    logic [CW:0] len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       len_q <= '0;
        else if (busy)    len_q <= (len_q == LEN_MAX) ? len_q : len_q + (CW+1)'(1);
        else              len_q <= '0;
    end

    // R4: every finished bus cycle held its request for at least BUS_CLKS clocks
    a_r4_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> (len_q >= LEN_MAX));

    // R3: address, direction and write data stay put until acceptance
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R5: an operand request seen while idle always gets the next cycle
    a_r5_data_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && data_want) |=> (cur == CYC_DATA));
endmodule

// File: rtl/fq_fetchptr.sv
// Code pointer and flush bookkeeping.
// Holds the byte address of the next code byte to enqueue, moves it to
// the target on a redirect, and marks a code fetch that was in flight
// at a redirect so that its returned word is dropped.
// Assumes only one bus cycle is ever outstanding.
module fq_fetchptr #(
    parameter int                ADDR_W   = 20,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jmp_valid,
    input  logic [ADDR_W-1:0] jmp_addr,
    input  logic              code_busy,
    input  logic              code_done,
    output logic [ADDR_W-1:0] ptr,
    output logic              accept,
    output logic [1:0]        push_n
);
    logic drop;

    assign accept = code_done && !drop && !jmp_valid;
    assign push_n = !accept ? 2'd0 : (ptr[0] ? 2'd1 : 2'd2);

    // Pointer: load target on redirect, step past enqueued bytes
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr <= RESET_PC;
        else if (jmp_valid)  ptr <= jmp_addr;
        else if (accept)     ptr <= ptr + (ptr[0] ? ADDR_W'(1) : ADDR_W'(2));
    end

    // Drop marker: set by a redirect during a code fetch, cleared at its end
    always_ff @(posedge clk) begin
        if (!rst_n)                                      drop <= 1'b0;
        else if (jmp_valid && code_busy && !code_done)   drop <= 1'b1;
        else if (code_done)                              drop <= 1'b0;
    end

    // R8: after an odd-pointer fetch the pointer is word aligned
    a_r8_realign: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ptr[0]) |=> !ptr[0]);

    // R7: a marked fetch ends without enqueuing and clears the marker
    a_r7_drop_once: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && code_done) |=> (!drop && !$past(accept)));
endmodule

// File: rtl/prefetch_queue_ctrl.sv
// Instruction prefetch queue controller (top).
// Keeps a byte store of prefetched code filled from a 16-bit memory
// port, serves operand accesses ahead of prefetching and flushes on a
// redirect. Little-endian byte lanes: bits 7:0 hold the even address.
// Assumes QDEPTH >= 2 and BUS_CLKS >= 2.
module prefetch_queue_ctrl import fq_pkg::*; #(
    parameter int                ADDR_W   = 20,
    parameter int                QDEPTH   = 6,
    parameter int                BUS_CLKS = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              eu_pop,
    output logic              eu_byte_valid,
    output logic [7:0]        eu_byte,
    input  logic              eu_jmp,
    input  logic [ADDR_W-1:0] eu_jmp_addr,
    input  logic              eu_data_req,
    input  logic              eu_data_we,
    input  logic [ADDR_W-1:0] eu_data_addr,
    input  logic [15:0]       eu_data_wdata,
    output logic              eu_data_done,
    output logic [15:0]       eu_data_rdata
);
    localparam int CNTW = $clog2(QDEPTH+1);
    localparam logic [CNTW-1:0] ROOM_LIM = CNTW'(QDEPTH - 2);

    logic [CNTW-1:0]   q_count;
    logic              code_want;
    logic [ADDR_W-1:0] fetch_ptr;
    logic [ADDR_W-1:0] fetch_addr;
    logic              bus_done;
    cyc_e              bus_cur;
    logic              code_done;
    logic              code_busy;
    logic              accept;
    logic [1:0]        push_n;
    logic [7:0]        push_b0;

    // Request a word only with two free slots and no redirect this clock
    assign code_want  = (q_count <= ROOM_LIM) && !eu_jmp;
    assign fetch_addr = {fetch_ptr[ADDR_W-1:1], 1'b0};
    assign code_busy  = (bus_cur == CYC_CODE);
    assign code_done  = bus_done && code_busy;

    // Lane select: an odd pointer starts at the high byte of the word
    assign push_b0 = fetch_ptr[0] ? mem_rdata[15:8] : mem_rdata[7:0];

    assign eu_data_done  = bus_done && (bus_cur == CYC_DATA);
    assign eu_data_rdata = mem_rdata;

    fq_busseq #(
        .ADDR_W   (ADDR_W),
        .BUS_CLKS (BUS_CLKS)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_want  (code_want),
        .code_addr  (fetch_addr),
        .data_want  (eu_data_req),
        .data_we    (eu_data_we),
        .data_addr  (eu_data_addr),
        .data_wdata (eu_data_wdata),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .done       (bus_done),
        .cur        (bus_cur)
    );

    fq_fetchptr #(
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .jmp_valid (eu_jmp),
        .jmp_addr  (eu_jmp_addr),
        .code_busy (code_busy),
        .code_done (code_done),
        .ptr       (fetch_ptr),
        .accept    (accept),
        .push_n    (push_n)
    );

    fq_bytequeue #(
        .DEPTH (QDEPTH)
    ) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (eu_jmp),
        .push_n  (push_n),
        .push_b0 (push_b0),
        .push_b1 (mem_rdata[15:8]),
        .pop     (eu_pop),
        .head    (eu_byte),
        .valid   (eu_byte_valid),
        .count   (q_count)
    );

    // R2: a code cycle only begins with two or more free slots
    a_r2_room: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && code_busy) |-> (q_count <= ROOM_LIM));

    // R6: a redirect leaves the store empty on the next clock
    a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
        eu_jmp |=> !eu_byte_valid);

    // R3: code cycles present a word-aligned address
    a_r3_code_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && code_busy) |-> (!mem_addr[0] && !mem_we));
endmodule

// File: tb/sim_prefetch_queue_ctrl.sv
// Directed bench for the prefetch queue controller: one task per scenario.
module sim_prefetch_queue_ctrl;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata, mem_rdata;
    logic          eu_pop, eu_byte_valid, eu_jmp;
    logic [7:0]    eu_byte;
    logic [AW-1:0] eu_jmp_addr, eu_data_addr;
    logic          eu_data_req, eu_data_we, eu_data_done;
    logic [15:0]   eu_data_wdata, eu_data_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    prefetch_queue_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .eu_pop(eu_pop), .eu_byte_valid(eu_byte_valid), .eu_byte(eu_byte),
        .eu_jmp(eu_jmp), .eu_jmp_addr(eu_jmp_addr),
        .eu_data_req(eu_data_req), .eu_data_we(eu_data_we),
        .eu_data_addr(eu_data_addr), .eu_data_wdata(eu_data_wdata),
        .eu_data_done(eu_data_done), .eu_data_rdata(eu_data_rdata)
    );

    // Memory content: one computed byte per address
    function automatic logic [7:0] fb(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h0} ^ 8'h3C;
    endfunction

    // Memory model: acknowledge on the lat-th clock of a request
    int            lat = 1;
    int            req_cnt = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    always @(posedge clk) begin
        if (!mem_req || mem_ack) req_cnt <= 0;
        else                     req_cnt <= req_cnt + 1;
        if (mem_req && mem_ack && mem_we) begin
            wr_addr <= mem_addr;
            wr_data <= mem_wdata;
        end
    end
    assign mem_ack   = mem_req && (req_cnt >= lat - 1);
    assign mem_rdata = {fb(mem_addr + 20'd1), fb(mem_addr)};

    // Bus monitor: logs cycle starts and request lengths shortly after each edge
    int            nstart = 0;
    logic [AW-1:0] alog [64];
    bit            dlog [64];
    int            align_err = 0;
    int            cur_len = 0;
    int            min_len = 1000;
    int            max_len = 0;
    logic          prev_req = 1'b0;
    always @(posedge clk) begin
        #1;
        if (mem_req && !prev_req) begin
            alog[nstart & 63] = mem_addr;
            dlog[nstart & 63] = eu_data_req;
            if (!eu_data_req && mem_addr[0]) align_err++;
            nstart++;
        end
        if (mem_req) cur_len++;
        else if (prev_req) begin
            if (cur_len < min_len) min_len = cur_len;
            if (cur_len > max_len) max_len = cur_len;
            cur_len = 0;
        end
        prev_req = mem_req;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pop_one(output logic [7:0] b);
        int n = 0;
        while (!eu_byte_valid && n < 300) begin @(negedge clk); n++; end
        b = eu_byte;
        eu_pop = 1'b1;
        @(negedge clk);
        eu_pop = 1'b0;
    endtask

    task automatic wait_start(input int n0);
        int n = 0;
        while (nstart == n0 && n < 300) begin @(negedge clk); n++; end
    endtask

    task automatic redirect(input logic [AW-1:0] a);
        eu_jmp_addr = a;
        eu_jmp = 1'b1;
        @(negedge clk);
        eu_jmp = 1'b0;
    endtask

    // R10: reset state and first fetch
    task automatic t_reset();
        int n0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 byte_valid in reset", 32'(eu_byte_valid), 0);
        chk("R10 mem_req in reset", 32'(mem_req), 0);
        n0 = nstart;
        rst_n = 1'b1;
        wait_start(n0);
        chk("R10 first fetch address", 32'(alog[n0 & 63]), 0);
        chk("R10 first cycle is code", 32'(dlog[n0 & 63]), 0);
    endtask

    // R1/R2: fill, room rule and byte order
    task automatic t_fill();
        logic [7:0] b;
        int n0;
        repeat (60) @(negedge clk);
        chk("R2 no fetch when full", 32'(mem_req), 0);
        n0 = nstart;
        pop_one(b);
        chk("R1 byte 0", 32'(b), 32'(fb(20'd0)));
        repeat (30) @(negedge clk);
        chk("R2 no fetch with one slot free", 32'(nstart), 32'(n0));
        pop_one(b);
        chk("R1 byte 1", 32'(b), 32'(fb(20'd1)));
        repeat (30) @(negedge clk);
        chk("R2 fetch with two slots free", 32'(nstart), 32'(n0 + 1));
        for (int i = 2; i < 8; i++) begin
            pop_one(b);
            chk("R1 byte order", 32'(b), 32'(fb(AW'(i))));
        end
    endtask

    // R6/R8/R9: odd redirect, pops on empty store
    task automatic t_jump_odd();
        logic [7:0] b;
        int n0;
        bit seen;
        lat = 4;
        n0 = nstart;
        eu_pop = 1'b1;             // pop in the redirect clock removes nothing
        redirect(20'h12345);
        chk("R6 store empty after redirect", 32'(eu_byte_valid), 0);
        seen = 1'b0;
        repeat (3) begin
            @(negedge clk);
            if (eu_byte_valid) seen = 1'b1;
        end
        eu_pop = 1'b0;
        chk("R9 empty pops held off", 32'(seen), 0);
        for (int i = 0; i < 4; i++) begin
            pop_one(b);
            chk("R8 bytes from odd target", 32'(b), 32'(fb(20'h12345 + AW'(i))));
        end
        chk("R6 first fetch at target word", 32'(alog[n0 & 63]), 32'h12344);
        chk("R8 next fetch word aligned", 32'(alog[(n0 + 1) & 63]), 32'h12346);
    endtask

    // R7: redirect during an in-flight code fetch
    task automatic t_drop();
        logic [7:0] b;
        int n0;
        lat = 10;
        n0 = nstart;
        redirect(20'h00100);
        wait_start(n0);
        repeat (2) @(negedge clk);
        redirect(20'h00200);
        chk("R7 old fetch still on bus", 32'(mem_req && mem_addr == 20'h00100), 1);
        for (int i = 0; i < 4; i++) begin
            pop_one(b);
            chk("R7 only target bytes", 32'(b), 32'(fb(20'h00200 + AW'(i))));
        end
        chk("R4 slow ack stretches cycle", 32'(max_len >= 10), 1);
    endtask

    // R5/R3: operand read and write pre-empt prefetching
    task automatic t_priority();
        logic [7:0] b;
        int n0, n1, n2, n;
        lat = 4;
        n0 = nstart;
        redirect(20'h00400);
        wait_start(n0);
        eu_data_addr = 20'h0ABCD;
        eu_data_we   = 1'b0;
        eu_data_req  = 1'b1;
        n1 = nstart;
        wait_start(n1);
        chk("R5 operand read wins next cycle", 32'(alog[n1 & 63]), 32'h0ABCD);
        n = 0;
        while (!eu_data_done && n < 100) begin @(negedge clk); n++; end
        chk("R5 read data", 32'(eu_data_rdata), 32'({fb(20'h0ABCE), fb(20'h0ABCD)}));
        n2 = nstart;
        eu_data_req = 1'b0;
        wait_start(n2);
        chk("R5 prefetch resumes", 32'(dlog[n2 & 63] == 1'b0 && alog[n2 & 63][0] == 1'b0), 1);
        eu_data_addr  = 20'h00F00;
        eu_data_we    = 1'b1;
        eu_data_wdata = 16'hBEEF;
        eu_data_req   = 1'b1;
        n = 0;
        while (!eu_data_done && n < 100) begin @(negedge clk); n++; end
        eu_data_req = 1'b0;
        eu_data_we  = 1'b0;
        @(negedge clk);
        chk("R3 write address", 32'(wr_addr), 32'h00F00);
        chk("R3 write data", 32'(wr_data), 32'hBEEF);
        pop_one(b);
        chk("R1 first byte after operand traffic", 32'(b), 32'(fb(20'h00400)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        eu_pop = 1'b0; eu_jmp = 1'b0; eu_jmp_addr = '0;
        eu_data_req = 1'b0; eu_data_we = 1'b0; eu_data_addr = '0; eu_data_wdata = '0;
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_jump_odd();
        t_drop();
        t_priority();
        chk("R3 code addresses even", 32'(align_err), 0);
        chk("R4 shortest cycle is four clocks", 32'(min_len), 4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule